// File: doc/BRIEF.md
# Double-Buffered Sound DMA Pointer Unit

This unit produces the byte address from which a sound fetch engine reads sample data. It holds a current buffer (a running pointer and an end address) and one queued buffer (a start and an end) that software fills in ahead of time. On every sample tick the running pointer moves forward by one 16-byte fetch block. When the pointer lands on the end of the current buffer, the queued buffer takes over if one is waiting. If none is waiting, the unit stops and holds its pointer.

Software programs the unit with write cycles in which the address bus carries everything: three address bits pick the operation, and a masked, shifted slice of the same address is the buffer value. The data bus plays no part. An interrupt flag tells software that the queued slot has been consumed and a new buffer should be supplied. A built-in divider derives the sample tick from the processor clock.

Top module: `snd_dma_ptr`

## Requirements
- R1: A write takes effect only when `wr_en` is high, and its operation is chosen by `wr_addr[19:17]`: 3'b100 loads the queued start, 3'b101 loads the queued end, 3'b110 forces a swap. Every other code (000, 001, 010, 011, 111) changes no state, and `wr_addr` is ignored when `wr_en` is low.
- R2: The value carried by a write is `(wr_addr & 26'h1FFFC0) << 2`, so every loaded address is a multiple of 256.
- R3: Loading the queued start marks the queued buffer valid. Loading the queued end leaves the valid flag as it was, so a buffer whose end alone was rewritten still halts at its end.
- R4: A sample tick occurs on the 24th rising edge after reset is released and then on every 24th edge after that.
- R5: On a tick while running, the pointer moves forward by 16. If the new pointer equals the current end and no queued buffer is valid, the pointer stays at that end and the unit halts. While halted, ticks have no effect on `fetch_addr`.
- R6: A swap, whether automatic (on a tick that reaches the end with a valid queued buffer) or forced, loads the pointer from the queued start, exchanges the current end with the queued end, clears the valid flag and leaves the halted state. `swap_pulse` is high for the one cycle after each swap edge.
- R7: After reset the unit is halted with `fetch_addr` = 0, no queued buffer valid, `irq` = 0 and `swap_pulse` = 0.
- R8: `irq` is set by an automatic swap and is cleared by a forced swap or by loading the queued start. It is never high while a queued buffer is valid.
- R9: When a write and a tick fall on the same edge, the write is applied first and the tick then acts on the updated state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 26 | Write address: holds the operation select and the value |
| fetch_addr | output | 26 | Current byte address for the next sample fetch |
| swap_pulse | output | 1 | High for one cycle after a buffer swap |
| irq | output | 1 | Request for software to queue another buffer |

## Verification
On every cycle the assertions check the following. The interrupt and a valid queued buffer never coexist. A halted pointer stays frozen unless a forced swap is written. A running tick without a write either advances the pointer by exactly 16 or produces a swap. Every swap pulse comes with the queued slot cleared and the unit running. Ticks are isolated single cycles, and the state after reset is as specified. Other behaviour depends on a whole buffer's worth of ticks, so only the bench scenarios can show it. This covers the exact edge on which the queued buffer takes over, the exchange of end addresses between buffers that share boundaries, the decoding of values whose select bits overlap the address field, halting at the end when only the end was rewritten, and the ordering of a write that shares an edge with a tick.

// File: rtl/snd_dma_pkg.sv
// Package: shared constants and types for the sound DMA pointer unit.
// Assumes the select field and value field positions below are fixed by the
// system address map; only widths that are local to this unit are parameters.
package snd_dma_pkg;

    // Position of the operation select field inside the write address.
    localparam int SEL_LO = 17;
    localparam int SEL_W  = 3;

    // Select codes understood by this unit (all others are ignored).
    localparam logic [SEL_W-1:0] OP_LOAD_START = 3'b100;
    localparam logic [SEL_W-1:0] OP_LOAD_END   = 3'b101;
    localparam logic [SEL_W-1:0] OP_FORCE_SWAP = 3'b110;

    // Value field: address bits VAL_HI..VAL_LO, moved up by VAL_SHIFT.
    localparam int VAL_LO    = 6;
    localparam int VAL_HI    = 20;
    localparam int VAL_SHIFT = 2;

    // One-hot decoded write command.
    typedef struct packed {
        logic load_start;
        logic load_end;
        logic force_swap;
    } snd_cmd_t;

endpackage

// File: rtl/snd_tick_div.sv
// Module: snd_tick_div
// Divides the processor clock down to the sample tick. The tick is high for
// one cycle out of every DIV, first on the DIV-th edge after reset release.
// Assumes DIV >= 2.
module snd_tick_div #(
    parameter int DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] count_q;

    // Tick is asserted during the final count of each period.
    always_comb begin
        tick = (count_q == LAST);
    end

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/snd_reg_decode.sv
// Module: snd_reg_decode
// Turns an address-only register write into a one-hot command and the buffer
// value extracted from the address. Purely combinational; the data bus is not
// an input. Assumes ADDR_W is wide enough to hold the shifted value field.
module snd_reg_decode
    import snd_dma_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output snd_cmd_t          cmd,
    output logic [ADDR_W-1:0] value
);
    localparam int OUT_LO = VAL_LO + VAL_SHIFT;
    localparam int OUT_HI = VAL_HI + VAL_SHIFT;

    logic [SEL_W-1:0] sel;

    // Pick the operation select out of the address.
    always_comb begin
        sel = wr_addr[SEL_LO +: SEL_W];
    end

    // Decode the select into a one-hot command, gated by the write strobe.
    always_comb begin
        cmd.load_start = wr_en && (sel == OP_LOAD_START);
        cmd.load_end   = wr_en && (sel == OP_LOAD_END);
        cmd.force_swap = wr_en && (sel == OP_FORCE_SWAP);
    end

    // Move the masked value field up to a 256-byte aligned address.
    always_comb begin
        value = '0;
        value[OUT_HI:OUT_LO] = wr_addr[VAL_HI:VAL_LO];
    end
endmodule

// File: rtl/snd_ptr_core.sv
// Module: snd_ptr_core
// Holds the current and queued buffers, advances the pointer on each tick,
// swaps or halts at the end of a buffer, and keeps the interrupt flag.
// A write in the same cycle as a tick is applied first (stage one), and the
// tick then works on the result (stage two). Assumes at most one command bit
// is set per cycle, which the decoder guarantees.
module snd_ptr_core
    import snd_dma_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int STEP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  snd_cmd_t          cmd,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              swap_pulse,
    output logic              irq,
    output logic              halted,
    output logic              next_valid
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Registered state.
    logic [ADDR_W-1:0] cur_ptr_q, cur_end_q, nxt_start_q, nxt_end_q;
    logic              valid_q, halt_q, irq_q, pulse_q;

    // Stage one: state after the register write.
    logic [ADDR_W-1:0] w_ptr, w_end, w_nstart, w_nend;
    logic              w_valid, w_halt, w_irq, w_swap;

    // Stage two: state after the tick.
    logic [ADDR_W-1:0] t_ptr, t_end, t_nend, t_adv;
    logic              t_valid, t_halt, t_irq, t_swap;

    // Stage one: apply a queued-start load, queued-end load or forced swap.
    always_comb begin
        w_ptr    = cur_ptr_q;
        w_end    = cur_end_q;
        w_nstart = nxt_start_q;
        w_nend   = nxt_end_q;
        w_valid  = valid_q;
        w_halt   = halt_q;
        w_irq    = irq_q;
        w_swap   = 1'b0;
        if (cmd.load_start) begin
            w_nstart = value;
            w_valid  = 1'b1;
            w_irq    = 1'b0;
        end
        if (cmd.load_end) begin
            w_nend = value;
        end
        if (cmd.force_swap) begin
            w_ptr   = nxt_start_q;
            w_end   = nxt_end_q;
            w_nend  = cur_end_q;
            w_valid = 1'b0;
            w_halt  = 1'b0;
            w_irq   = 1'b0;
            w_swap  = 1'b1;
        end
    end

    // Stage two: advance on a tick, then swap or halt at the buffer end.
    always_comb begin
        t_adv   = w_ptr + STEP_V;
        t_ptr   = w_ptr;
        t_end   = w_end;
        t_nend  = w_nend;
        t_valid = w_valid;
        t_halt  = w_halt;
        t_irq   = w_irq;
        t_swap  = w_swap;
        if (tick && !w_halt) begin
            if (t_adv != w_end) begin
                t_ptr = t_adv;
            end else if (w_valid) begin
                t_ptr   = w_nstart;
                t_end   = w_nend;
                t_nend  = w_end;
                t_valid = 1'b0;
                t_halt  = 1'b0;
                t_irq   = 1'b1;
                t_swap  = 1'b1;
            end else begin
                t_ptr  = t_adv;
                t_halt = 1'b1;
            end
        end
    end

    // State registers; reset leaves the unit halted with nothing queued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr_q   <= '0;
            cur_end_q   <= '0;
            nxt_start_q <= '0;
            nxt_end_q   <= '0;
            valid_q     <= 1'b0;
            halt_q      <= 1'b1;
            irq_q       <= 1'b0;
            pulse_q     <= 1'b0;
        end else begin
            cur_ptr_q   <= t_ptr;
            cur_end_q   <= t_end;
            nxt_start_q <= w_nstart;
            nxt_end_q   <= t_nend;
            valid_q     <= t_valid;
            halt_q      <= t_halt;
            irq_q       <= t_irq;
            pulse_q     <= t_swap;
        end
    end

    // Drive the outputs straight from registers.
    always_comb begin
        fetch_addr = cur_ptr_q;
        swap_pulse = pulse_q;
        irq        = irq_q;
        halted     = halt_q;
        next_valid = valid_q;
    end
endmodule

// File: rtl/snd_dma_ptr.sv
// Module: snd_dma_ptr (top)
// Double-buffered sound DMA pointer unit: tick divider, address-only register
// decoder and pointer core. Assumes writes arrive as single-cycle strobes.
module snd_dma_ptr
    import snd_dma_pkg::*;
#(
    parameter int ADDR_W   = 26,
    parameter int STEP     = 16,
    parameter int TICK_DIV = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              swap_pulse,
    output logic              irq
);
    logic              tick;
    snd_cmd_t          cmd;
    logic [ADDR_W-1:0] value;
    logic              halted;
    logic              next_valid;

    snd_tick_div #(
        .DIV(TICK_DIV)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    snd_reg_decode #(
        .ADDR_W(ADDR_W)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .cmd    (cmd),
        .value  (value)
    );

    snd_ptr_core #(
        .ADDR_W(ADDR_W),
        .STEP  (STEP)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd       (cmd),
        .value     (value),
        .fetch_addr(fetch_addr),
        .swap_pulse(swap_pulse),
        .irq       (irq),
        .halted    (halted),
        .next_valid(next_valid)
    );
endmodule

// File: rtl/snd_dma_ptr_chk.sv
// Module: snd_dma_ptr_chk
// Cycle-by-cycle properties of the sound DMA pointer unit, bound to the top.
// Assumes it sees the top's internal tick, halted and next_valid signals.
module snd_dma_ptr_chk
    import snd_dma_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int STEP   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              tick,
    input logic              halted,
    input logic              next_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              swap_pulse,
    input logic              irq
);
    logic [SEL_W-1:0] sel;
    always_comb sel = wr_addr[SEL_LO +: SEL_W];

    assert_irq_not_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !next_valid);

    assert_halt_freezes_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !(wr_en && sel == OP_FORCE_SWAP)) |=> $stable(fetch_addr));

    assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halted && !wr_en) |=>
            ((fetch_addr - $past(fetch_addr)) == ADDR_W'(STEP)) || swap_pulse);

    assert_swap_leaves_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (!next_valid && !halted));

    assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == OP_LOAD_START && !tick) |=> (next_valid && !irq));

    assert_reset_state_R7: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == '0 && !irq && halted && !next_valid && !swap_pulse));
endmodule

bind snd_dma_ptr snd_dma_ptr_chk #(
    .ADDR_W(ADDR_W),
    .STEP  (STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .tick      (tick),
    .halted    (halted),
    .next_valid(next_valid),
    .fetch_addr(fetch_addr),
    .swap_pulse(swap_pulse),
    .irq       (irq)
);

// File: tb/test_snd_dma_ptr.sv
`timescale 1ns/1ps
// Bench: directed sweeps plus a cycle-by-cycle arithmetic reference.
module test_snd_dma_ptr;
    localparam int AW   = 26;
    localparam int STEP = 16;
    localparam int DIV  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] fetch_addr;
    logic          swap_pulse;
    logic          irq;

    always #2 clk = ~clk;

    snd_dma_ptr i_snd_dma_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .fetch_addr(fetch_addr), .swap_pulse(swap_pulse), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int k      = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference state, following the requirements.
    logic [AW-1:0] m_ptr, m_end, m_ns, m_ne, m_tmp, m_adv;
    logic m_v, m_h, m_irq, m_sw, m_tk;

    function automatic logic [AW-1:0] val_of(input logic [AW-1:0] a);
        return (a & 26'h1FFFC0) << 2;
    endfunction

    task automatic model_swap();
        m_tmp = m_end; m_end = m_ne; m_ne = m_tmp;
        m_ptr = m_ns; m_v = 1'b0; m_h = 1'b0; m_sw = 1'b1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = '0; m_end = '0; m_ns = '0; m_ne = '0;
            m_v = 1'b0; m_h = 1'b1; m_irq = 1'b0; m_sw = 1'b0; k = 0;
        end else begin
            m_tk = ((k % DIV) == DIV - 1);
            k++;
            m_sw = 1'b0;
            if (wr_en) begin
                case (wr_addr[19:17])
                    3'b100: begin m_ns = val_of(wr_addr); m_v = 1'b1; m_irq = 1'b0; end
                    3'b101: m_ne = val_of(wr_addr);
                    3'b110: begin model_swap(); m_irq = 1'b0; end
                    default: ;
                endcase
            end
            if (m_tk && !m_h) begin
                m_adv = m_ptr + AW'(STEP);
                if (m_adv != m_end) m_ptr = m_adv;
                else if (m_v) begin model_swap(); m_irq = 1'b1; end
                else begin m_ptr = m_adv; m_h = 1'b1; end
            end
        end
    end

    // Compare every cycle against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(fetch_addr == m_ptr, "R5 fetch_addr vs reference", 32'(fetch_addr), 32'(m_ptr));
            chk(irq == m_irq, "R8 irq vs reference", 32'(irq), 32'(m_irq));
            chk(swap_pulse == m_sw, "R6 swap_pulse vs reference", 32'(swap_pulse), 32'(m_sw));
        end
    end

    // Write on an edge that carries no tick.
    task automatic wr(input logic [AW-1:0] a);
        @(negedge clk);
        while ((k % DIV) == DIV - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write on an edge that carries a tick.
    task automatic wr_on_tick(input logic [AW-1:0] a);
        @(negedge clk);
        while ((k % DIV) != DIV - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [AW-1:0] SWAP_A = AW'(3'b110) << 17;
    localparam logic [AW-1:0] MID    = 26'h280000;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [AW-1:0] s, e, s2, f0, a;
        logic i0;
        int c;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_addr == '0, "R7 reset fetch_addr", 32'(fetch_addr), 0);
        chk(irq == 1'b0, "R7 reset irq", 32'(irq), 0);
        chk(swap_pulse == 1'b0, "R7 reset swap_pulse", 32'(swap_pulse), 0);
        idle(60);
        chk(fetch_addr == '0, "R7 halted after reset", 32'(fetch_addr), 0);

        // R1: ignored select codes over several value patterns.
        for (int sel = 0; sel < 8; sel++) begin
            if (sel == 4 || sel == 5 || sel == 6) continue;
            for (int p = 0; p < 4; p++) begin
                a = ((AW'(p) * 26'h0155555) & ~(AW'(7) << 17)) | (AW'(sel) << 17);
                f0 = fetch_addr; i0 = irq;
                wr(a);
                chk(fetch_addr == f0, "R1 ignored select fetch_addr", 32'(fetch_addr), 32'(f0));
                chk(irq == i0, "R1 ignored select irq", 32'(irq), 32'(i0));
                chk(swap_pulse == 1'b0, "R1 ignored select no swap", 32'(swap_pulse), 0);
            end
        end
        // R1: strobe low with swap code on the bus.
        @(negedge clk); wr_addr = SWAP_A; idle(30);
        chk(swap_pulse == 1'b0 && fetch_addr == '0, "R1 wr_en low ignored", 32'(fetch_addr), 0);

        // Sweep over buffer placements around the start/end field boundary.
        for (int n = 1; n <= 2; n++) begin
            for (int m = 0; m <= 1; m++) begin
                s  = MID - AW'(n * 256);
                e  = MID + AW'(m * 256);
                s2 = s - 26'h100;
                wr(s >> 2); wr(e >> 2); wr(SWAP_A);
                chk(fetch_addr == s, "R2 R6 forced swap loads start", 32'(fetch_addr), 32'(s));
                chk(swap_pulse == 1'b1, "R6 forced swap pulse", 32'(swap_pulse), 1);
                chk(irq == 1'b0, "R8 forced swap clears irq", 32'(irq), 0);
                if (n == 1 && m == 0) begin
                    f0 = fetch_addr;
                    while (fetch_addr == f0) @(negedge clk);
                    f0 = fetch_addr; c = 0;
                    while (fetch_addr == f0) begin @(negedge clk); c++; end
                    chk(c == DIV, "R4 tick period", 32'(c), DIV);
                end
                wr(s2 >> 2); wr(e >> 2);
                chk(irq == 1'b0, "R8 start load leaves irq low", 32'(irq), 0);
                idle((n + m + 2) * 16 * DIV);
                chk(irq == 1'b1, "R8 auto swap raises irq", 32'(irq), 1);
                idle((n + m + 2) * 16 * DIV);
                chk(fetch_addr == e, "R5 halt at end", 32'(fetch_addr), 32'(e));
                f0 = fetch_addr; idle(100);
                chk(fetch_addr == f0, "R5 halted pointer frozen", 32'(fetch_addr), 32'(f0));
                wr(s2 >> 2);
                chk(irq == 1'b0, "R8 start load clears irq", 32'(irq), 0);
            end
        end

        // R3: end-only write does not queue a buffer.
        s = MID - 26'h200; e = MID;
        wr(s >> 2); wr(e >> 2); wr(SWAP_A); wr(e >> 2);
        idle(40 * DIV);
        chk(fetch_addr == e, "R3 end-only load halts at end", 32'(fetch_addr), 32'(e));

        // R9: forced swap sharing an edge with a tick.
        wr(s >> 2); wr(e >> 2);
        wr_on_tick(SWAP_A);
        chk(fetch_addr == s + 26'd16, "R9 swap then tick", 32'(fetch_addr), 32'(s + 26'd16));

        // R9: start load on the final tick of a buffer.
        s = MID - 26'h100; s2 = MID - 26'h300;
        wr(s >> 2); wr(SWAP_A);
        while (fetch_addr != e - 26'd16) @(negedge clk);
        wr_on_tick(s2 >> 2);
        chk(fetch_addr == s2, "R9 start load used by same-edge swap", 32'(fetch_addr), 32'(s2));
        chk(swap_pulse == 1'b1, "R9 same-edge swap pulse", 32'(swap_pulse), 1);
        chk(irq == 1'b1, "R9 R8 same-edge swap irq", 32'(irq), 1);

        idle(10);
        finish_run();
    end
endmodule